// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours in 24-hour form, a day-of-week count, the day of the month, the month and a two-digit year. A one-cycle tick input, produced once per second by a prescaler outside the block, advances the chain. Carries ripple from seconds up to the year within that single cycle. Month lengths and leap-year Februaries are handled without outside help.

A serial port around the block reads the registered fields in parallel whenever it needs a snapshot. It writes new values through a parallel load with a one-cycle strobe. While a serial write is being shifted in, the port raises a hold input, and any tick that arrives during hold is discarded. The load strobe is a plain control pin with no back-pressure: the block accepts a load in every cycle in which the strobe is high.

Field encodings are as follows. Each two-digit field carries its tens digit above a 4-bit units digit. The tens digit is 3 bits for seconds and minutes, 2 bits for hours and day of month, 1 bit for month and 4 bits for year. Day of week is a 3-bit binary value from 1 to 7. A field holding an illegal value returns to its first value on the next step that would pass its last value.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the fields read 00:00:00, day of week 1, day 01, month 01, year 00.
- R2: Each accepted tick moves seconds up by one in BCD (09 goes to 10) in the clock edge that samples it. From 59, seconds go to 00 and minutes advance. With no tick and no load, no field changes.
- R3: Minutes run 00 to 59 and carry into hours. Hours run 00 to 23, and the step after 23 returns them to 00 and starts a new day.
- R4: Day of week advances on every new day and goes from 7 back to 1.
- R5: In months 04, 06, 09 and 11, the day after 30 is 01 of the next month.
- R6: In months 01, 03, 05, 07, 08, 10 and 12, day 30 steps to 31, and the day after 31 is 01 of the next month.
- R7: In February the last day is 29 when the BCD year is a multiple of 4 (00 counts as one) and 28 otherwise.
- R8: After month 12 the month returns to 01 and the year advances. Year 99 steps to 00.
- R9: A load strobe writes all seven fields from the load inputs in the clock edge that samples it, and a tick in the same cycle is discarded.
- R10: While hold is high, ticks are discarded and no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle one-second pulse |
| hold_i | input | 1 | Discard ticks while high |
| ld_i | input | 1 | Load strobe for all fields |
| ld_sec_i | input | 7 | Seconds value to load, BCD |
| ld_min_i | input | 7 | Minutes value to load, BCD |
| ld_hour_i | input | 6 | Hours value to load, BCD |
| ld_wday_i | input | 3 | Day-of-week value to load, 1 to 7 |
| ld_mday_i | input | 6 | Day-of-month value to load, BCD |
| ld_mon_i | input | 5 | Month value to load, BCD |
| ld_year_i | input | 8 | Year value to load, BCD |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| wday_o | output | 3 | Day of week |
| mday_o | output | 6 | Day of month, BCD |
| mon_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
A few ticks from reset, plus a load of 09 seconds, show the BCD units-to-tens step. A load of 23:59:59 followed by one tick drives the whole carry ripple. Loads on the last day of a 30-day month, a 31-day month and December, each followed by one tick, separate the three month-length classes and the year rollover. February is tried with years 24, 00, 23 and 10, which tells the leap rule apart from a plain binary test on the low bits. A tick given together with a load, and a run of ticks under hold, show which input wins when more than one is active.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int UNITS_W   = 4;
  localparam int SEC_TW    = 3;
  localparam int MIN_TW    = 3;
  localparam int HOUR_TW   = 2;
  localparam int MDAY_TW   = 2;
  localparam int MON_TW    = 1;
  localparam int YEAR_TW   = 4;
  localparam int WDAY_W    = 3;
  localparam int SEC_W     = SEC_TW + UNITS_W;
  localparam int MIN_W     = MIN_TW + UNITS_W;
  localparam int HOUR_W    = HOUR_TW + UNITS_W;
  localparam int MDAY_W    = MDAY_TW + UNITS_W;
  localparam int MON_W     = MON_TW + UNITS_W;
  localparam int YEAR_W    = YEAR_TW + UNITS_W;

  localparam logic [SEC_W-1:0]  SEC_LAST  = 7'h59;
  localparam logic [MIN_W-1:0]  MIN_LAST  = 7'h59;
  localparam logic [HOUR_W-1:0] HOUR_LAST = 6'h23;
  localparam logic [MON_W-1:0]  MON_LAST  = 5'h12;
  localparam logic [YEAR_W-1:0] YEAR_LAST = 8'h99;
  localparam logic [WDAY_W-1:0] WDAY_FIRST = 3'd1;
  localparam logic [WDAY_W-1:0] WDAY_LAST  = 3'd7;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [WDAY_W-1:0] wday;
    logic [MDAY_W-1:0] mday;
    logic [MON_W-1:0]  mon;
    logic [YEAR_W-1:0] year;
  } cal_time_t;
endpackage

// File: rtl/cal_bcd_counter.sv
module cal_bcd_counter #(
  parameter int TENS_W = 3,
  parameter int UNITS_W = 4,
  parameter logic [TENS_W+UNITS_W-1:0] FIRST = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inc_i,
  input  logic                      wrap_i,
  input  logic                      ld_i,
  input  logic [TENS_W+UNITS_W-1:0] ld_val_i,
  output logic [TENS_W+UNITS_W-1:0] q_o
);
  localparam int W = TENS_W + UNITS_W;
  localparam logic [UNITS_W-1:0] UNITS_MAX = UNITS_W'(9);

  logic [W-1:0]       q;
  logic [W-1:0]       stepped;
  logic [UNITS_W-1:0] units;
  logic [TENS_W-1:0]  tens;

  assign units = q[UNITS_W-1:0];
  assign tens  = q[W-1:UNITS_W];

  always_comb begin
    if (wrap_i)
      stepped = FIRST;
    else if (units >= UNITS_MAX)
      stepped = {tens + TENS_W'(1), {UNITS_W{1'b0}}};
    else
      stepped = {tens, units + UNITS_W'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= FIRST;
    else if (ld_i)  q <= ld_val_i;
    else if (inc_i) q <= stepped;
  end

  assign q_o = q;
endmodule

// File: rtl/cal_month_days.sv
module cal_month_days
  import cal_pkg::*;
(
  input  logic [MON_W-1:0]  mon_i,
  input  logic [YEAR_W-1:0] year_i,
  output logic [MDAY_W-1:0] last_o
);
  logic leap;
  logic [UNITS_W-1:0] yu;

  assign yu = year_i[UNITS_W-1:0];

  always_comb begin
    if (year_i[UNITS_W])
      leap = (yu == 4'd2) || (yu == 4'd6);
    else
      leap = (yu == 4'd0) || (yu == 4'd4) || (yu == 4'd8);
  end

  always_comb begin
    unique case (mon_i)
      5'h02:                      last_o = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
      default:                    last_o = 6'h31;
    endcase
  end
endmodule

// File: rtl/cal_weekday.sv
module cal_weekday #(
  parameter int W = 3,
  parameter logic [W-1:0] FIRST = 1,
  parameter logic [W-1:0] LAST = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] stepped;

  assign stepped = (q >= LAST || q < FIRST) ? FIRST : q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= FIRST;
    else if (ld_i)  q <= ld_val_i;
    else if (inc_i) q <= stepped;
  end

  assign q_o = q;
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              hold_i,
  input  logic              ld_i,
  input  logic [SEC_W-1:0]  ld_sec_i,
  input  logic [MIN_W-1:0]  ld_min_i,
  input  logic [HOUR_W-1:0] ld_hour_i,
  input  logic [WDAY_W-1:0] ld_wday_i,
  input  logic [MDAY_W-1:0] ld_mday_i,
  input  logic [MON_W-1:0]  ld_mon_i,
  input  logic [YEAR_W-1:0] ld_year_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [WDAY_W-1:0] wday_o,
  output logic [MDAY_W-1:0] mday_o,
  output logic [MON_W-1:0]  mon_o,
  output logic [YEAR_W-1:0] year_o
);
  cal_time_t cur;
  logic [MDAY_W-1:0] mday_last;
  logic step_sec, step_min, step_hour, step_day, step_mon, step_year;
  logic last_sec, last_min, last_hour, last_mday, last_mon, last_year;

  // a load wins over a tick; hold swallows the tick entirely
  assign step_sec  = tick_i & ~hold_i & ~ld_i;
  assign last_sec  = cur.sec  >= SEC_LAST;
  assign last_min  = cur.min  >= MIN_LAST;
  assign last_hour = cur.hour >= HOUR_LAST;
  assign last_mday = cur.mday >= mday_last;
  assign last_mon  = cur.mon  >= MON_LAST;
  assign last_year = cur.year >= YEAR_LAST;

  assign step_min  = step_sec  & last_sec;
  assign step_hour = step_min  & last_min;
  assign step_day  = step_hour & last_hour;
  assign step_mon  = step_day  & last_mday;
  assign step_year = step_mon  & last_mon;

  cal_month_days u_days (.mon_i(cur.mon), .year_i(cur.year), .last_o(mday_last));

  cal_bcd_counter #(.TENS_W(SEC_TW), .UNITS_W(UNITS_W), .FIRST(7'h00)) u_sec (
    .clk, .rst_n, .inc_i(step_sec), .wrap_i(last_sec), .ld_i,
    .ld_val_i(ld_sec_i), .q_o(cur.sec));

  cal_bcd_counter #(.TENS_W(MIN_TW), .UNITS_W(UNITS_W), .FIRST(7'h00)) u_min (
    .clk, .rst_n, .inc_i(step_min), .wrap_i(last_min), .ld_i,
    .ld_val_i(ld_min_i), .q_o(cur.min));

  cal_bcd_counter #(.TENS_W(HOUR_TW), .UNITS_W(UNITS_W), .FIRST(6'h00)) u_hour (
    .clk, .rst_n, .inc_i(step_hour), .wrap_i(last_hour), .ld_i,
    .ld_val_i(ld_hour_i), .q_o(cur.hour));

  cal_weekday #(.W(WDAY_W), .FIRST(WDAY_FIRST), .LAST(WDAY_LAST)) u_wday (
    .clk, .rst_n, .inc_i(step_day), .ld_i, .ld_val_i(ld_wday_i), .q_o(cur.wday));

  cal_bcd_counter #(.TENS_W(MDAY_TW), .UNITS_W(UNITS_W), .FIRST(6'h01)) u_mday (
    .clk, .rst_n, .inc_i(step_day), .wrap_i(last_mday), .ld_i,
    .ld_val_i(ld_mday_i), .q_o(cur.mday));

  cal_bcd_counter #(.TENS_W(MON_TW), .UNITS_W(UNITS_W), .FIRST(5'h01)) u_mon (
    .clk, .rst_n, .inc_i(step_mon), .wrap_i(last_mon), .ld_i,
    .ld_val_i(ld_mon_i), .q_o(cur.mon));

  cal_bcd_counter #(.TENS_W(YEAR_TW), .UNITS_W(UNITS_W), .FIRST(8'h00)) u_year (
    .clk, .rst_n, .inc_i(step_year), .wrap_i(last_year), .ld_i,
    .ld_val_i(ld_year_i), .q_o(cur.year));

  assign sec_o  = cur.sec;
  assign min_o  = cur.min;
  assign hour_o = cur.hour;
  assign wday_o = cur.wday;
  assign mday_o = cur.mday;
  assign mon_o  = cur.mon;
  assign year_o = cur.year;
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              hold_i,
  input logic              ld_i,
  input logic [SEC_W-1:0]  ld_sec_i,
  input logic [MIN_W-1:0]  ld_min_i,
  input logic [HOUR_W-1:0] ld_hour_i,
  input logic [WDAY_W-1:0] ld_wday_i,
  input logic [MDAY_W-1:0] ld_mday_i,
  input logic [MON_W-1:0]  ld_mon_i,
  input logic [YEAR_W-1:0] ld_year_i,
  input logic [SEC_W-1:0]  sec_o,
  input logic [MIN_W-1:0]  min_o,
  input logic [HOUR_W-1:0] hour_o,
  input logic [WDAY_W-1:0] wday_o,
  input logic [MDAY_W-1:0] mday_o,
  input logic [MON_W-1:0]  mon_o,
  input logic [YEAR_W-1:0] year_o
);
  logic [41:0] all_q;
  logic        take;
  assign all_q = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
  assign take  = tick_i && !hold_i && !ld_i;

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_i) |=> $stable(all_q));

  p_sec_tens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sec_o == 7'h09) |=> (sec_o == 7'h10));

  p_weekday_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sec_o == 7'h59 && min_o == 7'h59 && hour_o == 6'h23 && wday_o == 3'd7)
      |=> (wday_o == 3'd1));

  p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sec_o == 7'h59 && min_o == 7'h59 && hour_o == 6'h23 &&
     mday_o == 6'h31 && mon_o == 5'h12 && year_o == 8'h99)
      |=> (year_o == 8'h00 && mon_o == 5'h01 && mday_o == 6'h01));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (all_q == $past({ld_sec_i, ld_min_i, ld_hour_i, ld_wday_i,
                              ld_mday_i, ld_mon_i, ld_year_i})));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !ld_i) |=> $stable(all_q));
endmodule

bind cal_clock_core cal_clock_checker u_chk (.*);

// File: tb/cal_clock_core_bench.sv
module cal_clock_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, hold_i = 1'b0, ld_i = 1'b0;
  logic [6:0] ld_sec_i = '0, ld_min_i = '0;
  logic [5:0] ld_hour_i = '0, ld_mday_i = '0;
  logic [2:0] ld_wday_i = '0;
  logic [4:0] ld_mon_i = '0;
  logic [7:0] ld_year_i = '0;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, mday_o;
  logic [2:0] wday_o;
  logic [4:0] mon_o;
  logic [7:0] year_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cal_clock_core u_cal_clock_core (.*);

  // packed view: sec, min, hour, wday, mday, mon, year
  function automatic logic [41:0] now();
    return {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
  endfunction

  task automatic chk(input string req, input logic [41:0] exp);
    checks++;
    if (now() !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, now(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [41:0] v);
    {ld_sec_i, ld_min_i, ld_hour_i, ld_wday_i, ld_mday_i, ld_mon_i, ld_year_i} = v;
    ld_i = 1'b1;
    step();
    ld_i = 1'b0;
  endtask

  task automatic tick1();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", {7'h00, 7'h00, 6'h00, 3'd1, 6'h01, 5'h01, 8'h00});
  endtask

  task automatic t_seconds();
    for (int i = 0; i < 3; i++) tick1();
    chk("R2 three ticks", {7'h03, 7'h00, 6'h00, 3'd1, 6'h01, 5'h01, 8'h00});
    step(); step();
    chk("R2 idle stable", {7'h03, 7'h00, 6'h00, 3'd1, 6'h01, 5'h01, 8'h00});
    load({7'h09, 7'h12, 6'h05, 3'd2, 6'h10, 5'h05, 8'h20});
    tick1();
    chk("R2 units to tens", {7'h10, 7'h12, 6'h05, 3'd2, 6'h10, 5'h05, 8'h20});
    load({7'h59, 7'h12, 6'h05, 3'd2, 6'h10, 5'h05, 8'h20});
    tick1();
    chk("R2 minute carry", {7'h00, 7'h13, 6'h05, 3'd2, 6'h10, 5'h05, 8'h20});
  endtask

  task automatic t_day_roll();
    load({7'h59, 7'h59, 6'h23, 3'd7, 6'h15, 5'h03, 8'h24});
    tick1();
    chk("R3 R4 midnight and weekday wrap", {7'h00, 7'h00, 6'h00, 3'd1, 6'h16, 5'h03, 8'h24});
    load({7'h59, 7'h59, 6'h12, 3'd3, 6'h15, 5'h03, 8'h24});
    tick1();
    chk("R3 hour carry", {7'h00, 7'h00, 6'h13, 3'd3, 6'h15, 5'h03, 8'h24});
    load({7'h59, 7'h59, 6'h23, 3'd3, 6'h15, 5'h03, 8'h24});
    tick1();
    chk("R4 weekday step", {7'h00, 7'h00, 6'h00, 3'd4, 6'h16, 5'h03, 8'h24});
  endtask

  task automatic t_months();
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h30, 5'h04, 8'h21});
    tick1();
    chk("R5 april end", {7'h00, 7'h00, 6'h00, 3'd2, 6'h01, 5'h05, 8'h21});
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h30, 5'h11, 8'h21});
    tick1();
    chk("R5 november end", {7'h00, 7'h00, 6'h00, 3'd2, 6'h01, 5'h12, 8'h21});
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h30, 5'h01, 8'h21});
    tick1();
    chk("R6 january 30", {7'h00, 7'h00, 6'h00, 3'd2, 6'h31, 5'h01, 8'h21});
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h31, 5'h08, 8'h21});
    tick1();
    chk("R6 august end", {7'h00, 7'h00, 6'h00, 3'd2, 6'h01, 5'h09, 8'h21});
  endtask

  task automatic t_feb();
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h28, 5'h02, 8'h24});
    tick1();
    chk("R7 leap 24 day 29", {7'h00, 7'h00, 6'h00, 3'd2, 6'h29, 5'h02, 8'h24});
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h29, 5'h02, 8'h24});
    tick1();
    chk("R7 leap 24 end", {7'h00, 7'h00, 6'h00, 3'd2, 6'h01, 5'h03, 8'h24});
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h28, 5'h02, 8'h00});
    tick1();
    chk("R7 leap 00", {7'h00, 7'h00, 6'h00, 3'd2, 6'h29, 5'h02, 8'h00});
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h28, 5'h02, 8'h23});
    tick1();
    chk("R7 common 23", {7'h00, 7'h00, 6'h00, 3'd2, 6'h01, 5'h03, 8'h23});
    load({7'h59, 7'h59, 6'h23, 3'd1, 6'h28, 5'h02, 8'h10});
    tick1();
    chk("R7 common 10", {7'h00, 7'h00, 6'h00, 3'd2, 6'h01, 5'h03, 8'h10});
  endtask

  task automatic t_year();
    load({7'h59, 7'h59, 6'h23, 3'd5, 6'h31, 5'h12, 8'h23});
    tick1();
    chk("R8 new year", {7'h00, 7'h00, 6'h00, 3'd6, 6'h01, 5'h01, 8'h24});
    load({7'h59, 7'h59, 6'h23, 3'd5, 6'h31, 5'h12, 8'h99});
    tick1();
    chk("R8 century wrap", {7'h00, 7'h00, 6'h00, 3'd6, 6'h01, 5'h01, 8'h00});
  endtask

  task automatic t_load_priority();
    tick_i = 1'b1;
    load({7'h42, 7'h17, 6'h08, 3'd6, 6'h22, 5'h07, 8'h55});
    tick_i = 1'b0;
    chk("R9 load beats tick", {7'h42, 7'h17, 6'h08, 3'd6, 6'h22, 5'h07, 8'h55});
  endtask

  task automatic t_hold();
    hold_i = 1'b1;
    for (int i = 0; i < 5; i++) tick1();
    chk("R10 ticks dropped", {7'h42, 7'h17, 6'h08, 3'd6, 6'h22, 5'h07, 8'h55});
    hold_i = 1'b0;
    tick1();
    chk("R10 release", {7'h43, 7'h17, 6'h08, 3'd6, 6'h22, 5'h07, 8'h55});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_day_roll();
    t_months();
    t_feb();
    t_year();
    t_load_priority();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule